// File: doc/BRIEF.md
# Unipolar Center-Aligned H-Bridge Gate Generator

This block drives the four gates of a full H-bridge that uses unipolar switching. A free-running period counter restarts at the beginning of every switching cycle. Each bridge leg compares that counter against an on-window that is symmetric about the restart point. The upper gate of a leg is on during that window, and the lower gate of the leg is the inverse. A single duty word sets leg A. Leg B takes the mirrored duty, so any increase in the leg-A duty is matched by an equal decrease in the leg-B duty.

The block also produces a one-cycle sampling strobe twice per switching period: once at the counter restart and once at the counter midpoint. These instants are the centres of the on-pulses and the off-pulses. An ADC started by this strobe therefore samples away from every switching edge, at twice the switching rate. The period and duty inputs take effect only at a period boundary, so a pulse that has already started is never reshaped.

Top module: `hb_pwm_unipolar`

## Requirements
- R1: A counter steps 0,1,...,P-1 and then returns to 0, where P is the period in clock cycles. A requested period below 4 is treated as 4.
- R2: With an N-bit duty d and FS = 2^N-1, let h = floor(d·P / (2·FS)). A leg's upper gate is high at count k when k < h or k ≥ P-h. This places the pulse symmetrically around count 0.
- R3: A duty of 0 keeps the upper gate low for the whole period. A duty of FS keeps it high for the whole period, with no single-cycle drop anywhere.
- R4: Leg B uses the duty FS - duty_a under the same rule as R2.
- R5: While enabled, gate_a_n is the inverse of gate_a and gate_b_n is the inverse of gate_b.
- R6: sample_trig is high for exactly one cycle at count 0 and for one cycle at count floor(P/2). It is low at every other count.
- R7: Period and duty are captured only when the counter is about to return to 0, or at any time while the block is disabled. A change made in the middle of a period has no effect until the next period starts.
- R8: With enable low, all four gates and sample_trig are low and the counter is held at 0. The first enabled cycle is count 0.
- R9: After reset the counter is at 0. With enable low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the bridge; low forces all outputs off |
| period | input | CNT_W | Switching period in clock cycles |
| duty_a | input | DUTY_W | Leg-A duty, full scale 2^DUTY_W-1 |
| gate_a | output | 1 | Leg A upper gate |
| gate_a_n | output | 1 | Leg A lower gate |
| gate_b | output | 1 | Leg B upper gate |
| gate_b_n | output | 1 | Leg B lower gate |
| sample_trig | output | 1 | One-cycle ADC start strobe |

## Verification
Several properties are checked on every cycle. The counter stays below the captured period and wraps to zero. It sits at zero whenever the block is disabled. The captured on-window does not move inside a running period. Every non-empty pulse covers the restart point. The strobe never lasts longer than one cycle. Other behaviour is shown only by the bench's scenarios: the exact pulse widths against the duty formula, the mirrored duty of leg B, strobe placement at the midpoint for odd and even periods, the clamp on very short periods, and the deferral of mid-period input changes.

// File: rtl/hb_pwm_pkg.sv
package hb_pwm_pkg;
   // smallest period that keeps the two strobes apart by at least one idle cycle
   localparam int unsigned PERIOD_FLOOR = 4;
   typedef enum int {
      LEG_A = 0,
      LEG_B = 1
   } leg_e;
endpackage

// File: rtl/hb_period_ctr.sv
module hb_period_ctr #(
   parameter int unsigned CNT_W   = 12,
   parameter int unsigned P_FLOOR = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] period_in,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] p_cur,
   output logic [CNT_W-1:0] p_next,
   output logic             load
);
   localparam logic [CNT_W-1:0] FLOOR_V = CNT_W'(P_FLOOR);

   assign p_next = (period_in < FLOOR_V) ? FLOOR_V : period_in;
   assign load   = !en || (cnt == p_cur - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         p_cur <= FLOOR_V;
      end else if (load) begin
         cnt   <= '0;
         p_cur <= p_next;
      end else begin
         cnt   <= cnt + 1'b1;
      end
   end

   // R1: count never reaches the captured period
   a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < p_cur);
   // R1: last count of a running period is followed by zero
   a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cnt == p_cur - 1'b1) |=> (cnt == '0));
   // R8: disabled cycle leaves the counter at zero
   a_r8_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0));
endmodule

// File: rtl/hb_leg.sv
module hb_leg #(
   parameter int unsigned DUTY_W = 10,
   parameter int unsigned CNT_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              load,
   input  logic [DUTY_W-1:0] duty,
   input  logic [CNT_W-1:0]  p_next,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [CNT_W-1:0]  p_cur,
   output logic              hi
);
   localparam int unsigned     PW   = DUTY_W + CNT_W;
   localparam logic [DUTY_W-1:0] FS = {DUTY_W{1'b1}};
   localparam logic [PW-1:0]   DEN  = PW'(2) * PW'(FS);

   logic [PW-1:0]    prod;
   logic [CNT_W-1:0] h_new, h_q;
   logic             full_q;

   assign prod  = PW'(duty) * PW'(p_next);
   assign h_new = CNT_W'(prod / DEN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h_q    <= '0;
         full_q <= 1'b0;
      end else if (load) begin
         h_q    <= h_new;
         full_q <= (duty == FS);
      end
   end

   assign hi = full_q || (cnt < h_q) || (cnt >= p_cur - h_q);

   // R7: on-window is frozen inside a running period
   a_r7_window_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && !$past(load)) |-> ($stable(h_q) && $stable(full_q)));
   // R2: a non-empty pulse always covers the restart point
   a_r2_centered: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && h_q != '0) |-> hi);
endmodule

// File: rtl/hb_pwm_unipolar.sv
module hb_pwm_unipolar
   import hb_pwm_pkg::*;
#(
   parameter int unsigned DUTY_W = 10,
   parameter int unsigned CNT_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [CNT_W-1:0]  period,
   input  logic [DUTY_W-1:0] duty_a,
   output logic              gate_a,
   output logic              gate_a_n,
   output logic              gate_b,
   output logic              gate_b_n,
   output logic              sample_trig
);
   localparam logic [DUTY_W-1:0] FS    = {DUTY_W{1'b1}};
   localparam int unsigned       N_LEG = 2;

   if (DUTY_W < 2) begin : g_bad_duty
      $error("hb_pwm_unipolar: DUTY_W must be at least 2");
   end
   if (CNT_W < 3) begin : g_bad_cnt
      $error("hb_pwm_unipolar: CNT_W must hold the period floor");
   end

   logic [CNT_W-1:0]  cnt, p_cur, p_next;
   logic              load;
   logic [DUTY_W-1:0] leg_duty [N_LEG];
   logic [N_LEG-1:0]  leg_hi;

   hb_period_ctr #(.CNT_W(CNT_W), .P_FLOOR(PERIOD_FLOOR)) u_ctr (
      .clk(clk), .rst_n(rst_n), .en(enable), .period_in(period),
      .cnt(cnt), .p_cur(p_cur), .p_next(p_next), .load(load)
   );

   assign leg_duty[LEG_A] = duty_a;
   assign leg_duty[LEG_B] = FS - duty_a;

   for (genvar g = 0; g < N_LEG; g++) begin : g_leg
      hb_leg #(.DUTY_W(DUTY_W), .CNT_W(CNT_W)) u_leg (
         .clk(clk), .rst_n(rst_n), .en(enable), .load(load),
         .duty(leg_duty[g]), .p_next(p_next), .cnt(cnt), .p_cur(p_cur),
         .hi(leg_hi[g])
      );
   end

   assign gate_a      = enable &&  leg_hi[LEG_A];
   assign gate_a_n    = enable && !leg_hi[LEG_A];
   assign gate_b      = enable &&  leg_hi[LEG_B];
   assign gate_b_n    = enable && !leg_hi[LEG_B];
   assign sample_trig = enable && (cnt == '0 || cnt == (p_cur >> 1));

   // R6: strobe is a single-cycle pulse
   a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      sample_trig |=> !sample_trig);
   // R5: upper and lower gate of a leg never conduct together
   a_r5_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_a && gate_a_n) && !(gate_b && gate_b_n));
endmodule

// File: tb/sim_hb_pwm_unipolar.sv
module sim_hb_pwm_unipolar;
   localparam int DW = 10;
   localparam int CW = 12;
   localparam int FS = 1023;
   localparam int NV = 8;
   localparam int TP [NV] = '{20, 20, 20, 21, 16, 17, 50, 64};
   localparam int TD [NV] = '{0, 1023, 512, 700, 1000, 100, 1022, 300};

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n, en;
   logic [CW-1:0] period;
   logic [DW-1:0] duty;
   wire           a, an, b, bn, trig;
   int            n_chk = 0, n_fail = 0;
   bit            done = 0;

   hb_pwm_unipolar #(.DUTY_W(DW), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .enable(en), .period(period), .duty_a(duty),
      .gate_a(a), .gate_a_n(an), .gate_b(b), .gate_b_n(bn), .sample_trig(trig)
   );

   function automatic int half_w(int d, int p);
      return (d * p) / (2 * FS);
   endfunction

   function automatic bit leg_exp(int d, int p, int k);
      if (d == FS) return 1'b1;
      return (k < half_w(d, p)) || (k >= p - half_w(d, p));
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_quiet(string req);
      #1;
      check({a, an, b, bn, trig} == 5'b0, req, "outputs while disabled",
            int'({a, an, b, bn, trig}), 0);
   endtask

   // walks one period starting at count 0; optional duty/period change at count chg_k
   task automatic run_period(int p, int d, int chg_k, int new_d, int new_p, string req);
      int bad_a = 0, bad_b = 0, bad_n = 0, bad_t = 0, hi_a = 0;
      for (int k = 0; k < p; k++) begin
         #1;
         if (a !== leg_exp(d, p, k)) bad_a++;
         if (b !== leg_exp(FS - d, p, k)) bad_b++;
         if (an !== !a || bn !== !b) bad_n++;
         if (trig !== (k == 0 || k == p / 2)) bad_t++;
         if (a === 1'b1) hi_a++;
         if (k == chg_k) begin
            duty   = DW'(new_d);
            period = CW'(new_p);
         end
         @(negedge clk);
      end
      check(bad_a == 0, req, "R2 leg A mismatched cycles", bad_a, 0);
      check(bad_b == 0, req, "R4 leg B mismatched cycles", bad_b, 0);
      check(bad_n == 0, req, "R5 complement mismatched cycles", bad_n, 0);
      check(bad_t == 0, req, "R6 strobe mismatched cycles", bad_t, 0);
      check(hi_a == (d == FS ? p : 2 * half_w(d, p)), req, "R2 leg A high count",
            hi_a, (d == FS ? p : 2 * half_w(d, p)));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; en = 1'b0; period = CW'(20); duty = '0;
      repeat (3) @(negedge clk);
      check_quiet("R9");
      rst_n = 1'b1;
      @(negedge clk);

      // vector table: R1 R2 R4 R5 R6 across even/odd periods and extreme duties
      for (int i = 0; i < NV; i++) begin
         period = CW'(TP[i]); duty = DW'(TD[i]);
         @(negedge clk);
         en = 1'b1;
         run_period(TP[i], TD[i], -1, TD[i], TP[i], "R2");
         en = 1'b0;
         check_quiet("R8");
         @(negedge clk);
      end

      // R3: zero and full-scale held over two consecutive periods
      period = CW'(18); duty = '0;
      @(negedge clk); en = 1'b1;
      run_period(18, 0, -1, 0, 18, "R3");
      run_period(18, 0, 17, FS, 18, "R3");
      run_period(18, FS, -1, FS, 18, "R3");
      en = 1'b0; @(negedge clk);

      // R7: mid-period duty change deferred, then period change deferred
      period = CW'(24); duty = DW'(200);
      @(negedge clk); en = 1'b1;
      run_period(24, 200, 5, 900, 24, "R7");
      run_period(24, 900, 3, 900, 30, "R7");
      run_period(30, 900, -1, 900, 30, "R7");
      en = 1'b0; @(negedge clk);

      // R1: period below the floor runs as 4
      period = CW'(1); duty = DW'(512);
      @(negedge clk); en = 1'b1;
      run_period(4, 512, -1, 512, 1, "R1");
      run_period(4, 512, -1, 512, 1, "R1");
      en = 1'b0; @(negedge clk);

      // R8: drop enable mid-period, stay quiet, restart at count 0
      period = CW'(20); duty = DW'(600);
      @(negedge clk); en = 1'b1;
      repeat (7) @(negedge clk);
      en = 1'b0;
      check_quiet("R8");
      @(negedge clk); check_quiet("R8");
      @(negedge clk);
      en = 1'b1;
      run_period(20, 600, -1, 600, 20, "R8");
      en = 1'b0;

      // R9: reset in the middle of a run, then a clean start
      @(negedge clk); en = 1'b1;
      repeat (5) @(negedge clk);
      en = 1'b0; rst_n = 1'b0;
      @(negedge clk); check_quiet("R9");
      rst_n = 1'b1;
      @(negedge clk); en = 1'b1;
      run_period(20, 600, -1, 600, 20, "R9");
      en = 1'b0;

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule